// File: doc/BRIEF.md
# PCI configuration access translator

This block sits between a host that issues PCI configuration requests and a memory-mapped window onto the downstream configuration space. A request names a bus, a device, a function, a register offset, a size of 1, 2 or 4 bytes and a direction. The block checks that the request is legal and reachable. It then writes a value to a window-select register and performs 32-bit accesses on the window. Those are one read, one write, or a read followed by a write for sub-word stores.

Bus 0 targets are reached with type 0 cycles. Each device selects itself through a one-hot select bit. The upper part of that bit is carried in the window-select value and the lower part in the access address. Other buses use type 1 cycles, with bus, device and function packed into the address. Reads return the addressed bytes shifted down to bit 0. A downstream error abandons the access and returns all ones. One request is in flight at a time, and each completes with a single done pulse that carries data and a status.

Top module: `pci_cfg_xlate`

## Requirements
- R1: `req_ready_o` is high only when no request is in flight, and it is low in the cycle after an accept. `done_o` is a one-cycle pulse, and `req_ready_o` is high again in the cycle after it.
- R2: A size other than 1, 2 or 4 completes with status 1 (invalid) and data 0. It causes no window write and no downstream access.
- R3: On bus 0, a device number of 16 or more completes with status 1 and no window write or downstream access.
- R4: With `cardbus_i` high, any device number above 1 completes with status 1 and no window write or downstream access, on any bus.
- R5: For bus 0, let sel = 1 << (device + 16). The window value is 2 | (sel & WIN_MASK). The access address is CFG_BASE | (sel & ~WIN_MASK) | function<<8 | (offset & ~3). With the defaults, WIN_MASK = 0xFC000000 and CFG_BASE = 0x0C000000.
- R6: For a nonzero bus, the window value is 3. The address is CFG_BASE | bus<<16 | device<<11 | function<<8 | (offset & ~3).
- R7: Every accepted legal request issues exactly one window write (`win_we_o` high for one cycle). That write comes in the cycle before its first downstream access.
- R8: A read returns the 32-bit word shifted right by 8*(offset mod 4) and masked to 8, 16 or 32 bits for sizes 1, 2 and 4. Its status is 0 (ok).
- R9: A 1- or 2-byte write reads the word and clears the 0xFF or 0xFFFF lane at the shift 8*(offset mod 4). It ORs in the new data there and writes the word back to the same address. It completes with status 0 and data 0.
- R10: A 4-byte write issues a single write of the request data, with no read.
- R11: If `mem_err_i` is high on a completing downstream access, the request ends with status 2 (not found) and data 0xFFFFFFFF. An errored read in a sub-word write issues no write.
- R12: `done_o` rises 1 cycle after the accepting edge for a rejected request. It rises 3 cycles after for a read, a 4-byte write or an errored sub-word write, and 4 cycles after for a completed sub-word write, given zero-wait downstream responses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cardbus_i | input | 1 | Only devices 0 and 1 are reachable |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_bus_i | input | 8 | Bus number |
| req_dev_i | input | 5 | Device number |
| req_func_i | input | 3 | Function number |
| req_off_i | input | 8 | Register byte offset |
| req_size_i | input | 3 | Access size in bytes |
| req_wdata_i | input | 32 | Write data, right aligned |
| win_we_o | output | 1 | Window-select register write strobe |
| win_data_o | output | 32 | Window-select register value |
| mem_valid_o | output | 1 | Downstream access request |
| mem_write_o | output | 1 | Downstream access is a write |
| mem_addr_o | output | 32 | Downstream word address |
| mem_wdata_o | output | 32 | Downstream write word |
| mem_ready_i | input | 1 | Downstream access completes |
| mem_rdata_i | input | 32 | Downstream read word |
| mem_err_i | input | 1 | Downstream bus error with ready |
| done_o | output | 1 | Completion pulse |
| done_status_o | output | 2 | 0 ok, 1 invalid, 2 not found |
| done_rdata_o | output | 32 | Read data or all ones on error |

## Verification
A rejected request completes one cycle after the accepting edge. A read, a full-word write or an errored sub-word write completes three cycles after it, and a completed read-modify-write four. The window write always lands on the first cycle after acceptance. The bench drives on falling edges and counts falling edges from the accept until `done_o` is seen. It compares that count with the latency of the request class and only then samples status and data, so a result that arrives early or late fails the latency check rather than being missed. The window and downstream traffic are logged at rising edges and compared once the request has completed.

// File: rtl/pci_cfg_pkg.sv
package pci_cfg_pkg;
  typedef enum logic [1:0] {
    CFG_OK        = 2'd0,
    CFG_INVALID   = 2'd1,
    CFG_NOT_FOUND = 2'd2
  } cfg_status_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WIN,
    S_RD,
    S_WR,
    S_DONE
  } cfg_state_e;
endpackage

// File: rtl/pci_cfg_decode.sv
module pci_cfg_decode #(
  parameter int          BUS_W     = 8,
  parameter int          DEV_W     = 5,
  parameter int          FUNC_W    = 3,
  parameter int          OFF_W     = 8,
  parameter int          SIZE_W    = 3,
  parameter int          AW        = 32,
  parameter int          SLOT_MAX  = 16,
  parameter int          IDSEL_LSB = 16,
  parameter logic [31:0] CFG_BASE  = 32'h0C00_0000,
  parameter logic [31:0] WIN_MASK  = 32'hFC00_0000,
  parameter logic [31:0] T0_CODE   = 32'h0000_0002,
  parameter logic [31:0] T1_CODE   = 32'h0000_0003
) (
  input  logic [BUS_W-1:0]  bus_i,
  input  logic [DEV_W-1:0]  dev_i,
  input  logic [FUNC_W-1:0] func_i,
  input  logic [OFF_W-3:0]  off_word_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              cardbus_i,
  output logic [AW-1:0]     addr_o,
  output logic [AW-1:0]     win_o,
  output logic              reject_o
);
  logic [AW-1:0] sel;
  logic [AW-1:0] low_bits;
  logic          size_ok, type0, unreachable;

  assign size_ok  = (size_i == SIZE_W'(1)) || (size_i == SIZE_W'(2)) || (size_i == SIZE_W'(4));
  assign type0    = (bus_i == '0);
  assign sel      = AW'(1) << (AW'(dev_i) + AW'(IDSEL_LSB));
  assign low_bits = (AW'(func_i) << 8) | (AW'(off_word_i) << 2);

  assign unreachable = (cardbus_i && (32'(dev_i) > 1)) ||
                       (type0 && (32'(dev_i) >= SLOT_MAX));
  assign reject_o    = !size_ok || unreachable;

  always_comb begin
    if (type0) begin
      addr_o = AW'(CFG_BASE) | (sel & ~AW'(WIN_MASK)) | low_bits;
      win_o  = AW'(T0_CODE) | (sel & AW'(WIN_MASK));
    end else begin
      addr_o = AW'(CFG_BASE) | (AW'(bus_i) << 16) | (AW'(dev_i) << 11) | low_bits;
      win_o  = AW'(T1_CODE);
    end
  end
endmodule

// File: rtl/pci_cfg_lane.sv
module pci_cfg_lane #(
  parameter int DW     = 32,
  parameter int SIZE_W = 3
) (
  input  logic [DW-1:0]     word_i,
  input  logic [1:0]        off_lo_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rd_o,
  output logic [DW-1:0]     merged_o
);
  logic [4:0]    sh;
  logic [DW-1:0] lane_mask;

  assign sh = {off_lo_i, 3'b000};

  always_comb begin
    if (size_i == SIZE_W'(1))      lane_mask = DW'(8'hFF);
    else if (size_i == SIZE_W'(2)) lane_mask = DW'(16'hFFFF);
    else                           lane_mask = '1;
  end

  assign rd_o     = (word_i >> sh) & lane_mask;
  assign merged_o = (word_i & ~(lane_mask << sh)) | ((wdata_i & lane_mask) << sh);
endmodule

// File: rtl/pci_cfg_xlate.sv
module pci_cfg_xlate
  import pci_cfg_pkg::*;
#(
  parameter int          BUS_W     = 8,
  parameter int          DEV_W     = 5,
  parameter int          FUNC_W    = 3,
  parameter int          OFF_W     = 8,
  parameter int          SIZE_W    = 3,
  parameter int          AW        = 32,
  parameter int          DW        = 32,
  parameter int          SLOT_MAX  = 16,
  parameter int          IDSEL_LSB = 16,
  parameter logic [31:0] CFG_BASE  = 32'h0C00_0000,
  parameter logic [31:0] WIN_MASK  = 32'hFC00_0000,
  parameter logic [31:0] T0_CODE   = 32'h0000_0002,
  parameter logic [31:0] T1_CODE   = 32'h0000_0003
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cardbus_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [BUS_W-1:0]  req_bus_i,
  input  logic [DEV_W-1:0]  req_dev_i,
  input  logic [FUNC_W-1:0] req_func_i,
  input  logic [OFF_W-1:0]  req_off_i,
  input  logic [SIZE_W-1:0] req_size_i,
  input  logic [DW-1:0]     req_wdata_i,
  output logic              win_we_o,
  output logic [AW-1:0]     win_data_o,
  output logic              mem_valid_o,
  output logic              mem_write_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic [DW-1:0]     mem_rdata_i,
  input  logic              mem_err_i,
  output logic              done_o,
  output logic [1:0]        done_status_o,
  output logic [DW-1:0]     done_rdata_o
);
  localparam logic [SIZE_W-1:0] SIZE_WORD = SIZE_W'(4);

  cfg_state_e        state_q;
  cfg_status_e       status_q;
  logic              write_q;
  logic [1:0]        off_lo_q;
  logic [SIZE_W-1:0] size_q;
  logic [DW-1:0]     wdata_q, rdata_q;
  logic [AW-1:0]     addr_q, win_q;

  logic [AW-1:0]     dec_addr, dec_win;
  logic              dec_reject;
  logic [DW-1:0]     lane_rd, lane_merged;
  logic              accept;

  pci_cfg_decode #(
    .BUS_W(BUS_W), .DEV_W(DEV_W), .FUNC_W(FUNC_W), .OFF_W(OFF_W), .SIZE_W(SIZE_W),
    .AW(AW), .SLOT_MAX(SLOT_MAX), .IDSEL_LSB(IDSEL_LSB), .CFG_BASE(CFG_BASE),
    .WIN_MASK(WIN_MASK), .T0_CODE(T0_CODE), .T1_CODE(T1_CODE)
  ) u_decode (
    .bus_i      (req_bus_i),
    .dev_i      (req_dev_i),
    .func_i     (req_func_i),
    .off_word_i (req_off_i[OFF_W-1:2]),
    .size_i     (req_size_i),
    .cardbus_i  (cardbus_i),
    .addr_o     (dec_addr),
    .win_o      (dec_win),
    .reject_o   (dec_reject)
  );

  pci_cfg_lane #(.DW(DW), .SIZE_W(SIZE_W)) u_lane (
    .word_i   (mem_rdata_i),
    .off_lo_i (off_lo_q),
    .size_i   (size_q),
    .wdata_i  (wdata_q),
    .rd_o     (lane_rd),
    .merged_o (lane_merged)
  );

  assign accept = (state_q == S_IDLE) && req_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      status_q <= CFG_OK;
      write_q  <= 1'b0;
      off_lo_q <= '0;
      size_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      addr_q   <= '0;
      win_q    <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (accept) begin
          write_q  <= req_write_i;
          off_lo_q <= req_off_i[1:0];
          size_q   <= req_size_i;
          wdata_q  <= req_wdata_i;
          addr_q   <= dec_addr;
          win_q    <= dec_win;
          rdata_q  <= '0;
          status_q <= dec_reject ? CFG_INVALID : CFG_OK;
          state_q  <= dec_reject ? S_DONE : S_WIN;
        end
        S_WIN: state_q <= (write_q && size_q == SIZE_WORD) ? S_WR : S_RD;
        S_RD: if (mem_ready_i) begin
          if (mem_err_i) begin
            rdata_q  <= '1;
            status_q <= CFG_NOT_FOUND;
            state_q  <= S_DONE;
          end else if (write_q) begin
            wdata_q <= lane_merged;
            state_q <= S_WR;
          end else begin
            rdata_q <= lane_rd;
            state_q <= S_DONE;
          end
        end
        S_WR: if (mem_ready_i) begin
          if (mem_err_i) begin
            rdata_q  <= '1;
            status_q <= CFG_NOT_FOUND;
          end
          state_q <= S_DONE;
        end
        S_DONE: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready_o   = (state_q == S_IDLE);
  assign win_we_o      = (state_q == S_WIN);
  assign win_data_o    = win_q;
  assign mem_valid_o   = (state_q == S_RD) || (state_q == S_WR);
  assign mem_write_o   = (state_q == S_WR);
  assign mem_addr_o    = addr_q;
  assign mem_wdata_o   = wdata_q;
  assign done_o        = (state_q == S_DONE);
  assign done_status_o = status_q;
  assign done_rdata_o  = rdata_q;
endmodule

// File: rtl/pci_cfg_xlate_chk.sv
module pci_cfg_xlate_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          req_ready_o,
  input logic          win_we_o,
  input logic          mem_valid_o,
  input logic          mem_write_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_ready_i,
  input logic          mem_err_i,
  input logic          done_o,
  input logic [1:0]    done_status_o,
  input logic [DW-1:0] done_rdata_o
);
  logic win_seen, mem_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_seen <= 1'b0;
      mem_seen <= 1'b0;
    end else if (req_valid_i && req_ready_o) begin
      win_seen <= 1'b0;
      mem_seen <= 1'b0;
    end else begin
      if (win_we_o)    win_seen <= 1'b1;
      if (mem_valid_o) mem_seen <= 1'b1;
    end
  end

  // R1
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && req_ready_o));

  // R1
  busy_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  // R7
  win_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> win_seen);

  // R2
  invalid_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && done_status_o == 2'd1) |-> (!win_seen && !mem_seen));

  // R11
  err_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && done_status_o == 2'd2) |-> (done_rdata_o == '1));

  // R11
  err_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_write_o && mem_ready_i && mem_err_i) |=> !mem_valid_o);

  // R9
  rmw_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && mem_write_o && $past(mem_valid_o)) |-> $stable(mem_addr_o));
endmodule

bind pci_cfg_xlate pci_cfg_xlate_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/pci_cfg_xlate_tb.sv
module pci_cfg_xlate_tb;
  localparam logic [31:0] CFG_BASE = 32'h0C00_0000;
  localparam logic [31:0] WIN_MASK = 32'hFC00_0000;

  typedef struct packed {
    logic        wr;
    logic        cb;
    logic [7:0]  bus;
    logic [4:0]  dev;
    logic [2:0]  fn;
    logic [7:0]  off;
    logic [2:0]  sz;
    logic [31:0] wd;
    logic [1:0]  st;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 8'd0, 5'd3,  3'd0, 8'h00, 3'd4, 32'h0,         2'd0},
    '{1'b0, 1'b0, 8'd0, 5'd12, 3'd1, 8'h0E, 3'd2, 32'h0,         2'd0},
    '{1'b0, 1'b0, 8'd2, 5'd20, 3'd5, 8'h43, 3'd1, 32'h0,         2'd0},
    '{1'b0, 1'b0, 8'd0, 5'd16, 3'd0, 8'h00, 3'd4, 32'h0,         2'd1},
    '{1'b0, 1'b0, 8'd1, 5'd2,  3'd0, 8'h00, 3'd3, 32'h0,         2'd1},
    '{1'b0, 1'b1, 8'd3, 5'd2,  3'd0, 8'h00, 3'd4, 32'h0,         2'd1},
    '{1'b0, 1'b1, 8'd0, 5'd1,  3'd0, 8'h03, 3'd2, 32'h0,         2'd0},
    '{1'b1, 1'b0, 8'd0, 5'd4,  3'd2, 8'h05, 3'd1, 32'h0000_77AB, 2'd0},
    '{1'b1, 1'b0, 8'd1, 5'd7,  3'd0, 8'h06, 3'd2, 32'hFF12_1234, 2'd0},
    '{1'b1, 1'b0, 8'd0, 5'd5,  3'd0, 8'h10, 3'd4, 32'hDEAD_BEEF, 2'd0},
    '{1'b0, 1'b0, 8'd0, 5'd2,  3'd7, 8'h08, 3'd4, 32'h0,         2'd2},
    '{1'b1, 1'b0, 8'd0, 5'd2,  3'd7, 8'h09, 3'd1, 32'h0000_0055, 2'd2},
    '{1'b1, 1'b0, 8'd4, 5'd9,  3'd7, 8'h0C, 3'd4, 32'h1111_2222, 2'd2},
    '{1'b1, 1'b0, 8'd0, 5'd1,  3'd0, 8'h00, 3'd0, 32'h0,         2'd1},
    '{1'b0, 1'b0, 8'd0, 5'd4,  3'd2, 8'h04, 3'd4, 32'h0,         2'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cardbus = 1'b0, req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_bus = '0, req_off = '0;
  logic [4:0] req_dev = '0;
  logic [2:0] req_func = '0, req_size = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, win_we, mem_valid, mem_write, mem_ready, mem_err, done;
  logic [31:0] win_data, mem_addr, mem_wdata, done_rdata;
  logic [31:0] mem_rdata = '0;
  logic [1:0] done_status;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  pci_cfg_xlate u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cardbus_i(cardbus),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_bus_i(req_bus), .req_dev_i(req_dev), .req_func_i(req_func),
    .req_off_i(req_off), .req_size_i(req_size), .req_wdata_i(req_wdata),
    .win_we_o(win_we), .win_data_o(win_data),
    .mem_valid_o(mem_valid), .mem_write_o(mem_write), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata),
    .mem_err_i(mem_err), .done_o(done), .done_status_o(done_status),
    .done_rdata_o(done_rdata)
  );

  // downstream model: zero wait, function 7 answers with a bus error
  logic [31:0] mem_q [logic [31:0]];

  function automatic logic [31:0] mread(logic [31:0] a);
    return mem_q.exists(a) ? mem_q[a] : (a ^ 32'h5A5A_C3C3);
  endfunction

  assign mem_ready = mem_valid;
  assign mem_err   = mem_valid && (mem_addr[10:8] == 3'd7);
  always @(negedge clk) mem_rdata = mread(mem_addr);

  logic mon_clr = 1'b0;
  int win_cnt, rd_cnt, wr_cnt;
  logic order_bad;
  logic [31:0] last_win, last_raddr, last_waddr, last_wdata;

  always @(posedge clk) begin
    if (mon_clr) begin
      win_cnt = 0; rd_cnt = 0; wr_cnt = 0; order_bad = 1'b0;
      last_win = '0; last_raddr = '0; last_waddr = '0; last_wdata = '0;
    end else begin
      if (mem_valid && win_cnt == 0) order_bad = 1'b1;
      if (win_we) begin win_cnt++; last_win = win_data; end
      if (mem_valid && mem_ready) begin
        if (mem_write) begin
          wr_cnt++; last_waddr = mem_addr; last_wdata = mem_wdata;
          if (!mem_err) mem_q[mem_addr] = mem_wdata;
        end else begin
          rd_cnt++; last_raddr = mem_addr;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] e_addr(logic [7:0] bus, logic [4:0] dev,
                                         logic [2:0] fn, logic [7:0] off);
    logic [31:0] sel = 32'h1 << (32'(dev) + 16);
    logic [31:0] lo  = (32'(fn) << 8) | (32'(off) & 32'hFC);
    if (bus == 0) return CFG_BASE | (sel & ~WIN_MASK) | lo;
    return CFG_BASE | (32'(bus) << 16) | (32'(dev) << 11) | lo;
  endfunction

  function automatic logic [31:0] e_win(logic [7:0] bus, logic [4:0] dev);
    if (bus == 0) return 32'h2 | ((32'h1 << (32'(dev) + 16)) & WIN_MASK);
    return 32'h3;
  endfunction

  function automatic logic [31:0] lmask(logic [2:0] sz);
    return (sz == 3'd1) ? 32'hFF : (sz == 3'd2) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  task automatic run_vec(input vec_t v);
    logic [31:0] addr, word, exp_rd, exp_wd;
    bit legal, rej, err, sub_wr;
    int lat, exp_lat, exp_rdc, exp_wrc;
    string rs;
    @(negedge clk) mon_clr = 1'b1;
    @(negedge clk) mon_clr = 1'b0;
    addr   = e_addr(v.bus, v.dev, v.fn, v.off);
    word   = mread(addr);
    legal  = (v.sz == 3'd1) || (v.sz == 3'd2) || (v.sz == 3'd4);
    rej    = !legal || (v.cb && v.dev > 1) || (v.bus == 0 && v.dev >= 16);
    err    = !rej && (v.fn == 3'd7);
    sub_wr = v.wr && (v.sz != 3'd4);
    exp_rd = rej ? 32'h0 : err ? 32'hFFFF_FFFF : v.wr ? 32'h0
           : ((word >> (8 * v.off[1:0])) & lmask(v.sz));
    exp_wd = sub_wr ? ((word & ~(lmask(v.sz) << (8 * v.off[1:0])))
                      | ((v.wd & lmask(v.sz)) << (8 * v.off[1:0]))) : v.wd;
    exp_lat = rej ? 1 : (sub_wr && !err) ? 4 : 3;
    exp_rdc = (rej || (v.wr && !sub_wr)) ? 0 : 1;
    exp_wrc = (rej || !v.wr || (sub_wr && err)) ? 0 : 1;
    rs = rej ? (!legal ? "R2" : v.cb ? "R4" : "R3") : err ? "R11"
       : sub_wr ? "R9" : v.wr ? "R10" : "R8";

    cardbus = v.cb; req_write = v.wr; req_bus = v.bus; req_dev = v.dev;
    req_func = v.fn; req_off = v.off; req_size = v.sz; req_wdata = v.wd;
    req_valid = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (lat == 1) begin
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R1", "ready while busy", 32'(req_ready), 32'h0);
      end
    end while (!done && lat < 20);

    chk(lat == exp_lat, "R12", "done latency", 32'(lat), 32'(exp_lat));
    chk(done_status == v.st, rs, "status", 32'(done_status), 32'(v.st));
    chk(done_rdata == exp_rd, err ? "R11" : "R8", "done data", done_rdata, exp_rd);
    chk(win_cnt == (rej ? 0 : 1), "R7", "window writes", 32'(win_cnt), rej ? 32'h0 : 32'h1);
    chk(rd_cnt == exp_rdc, rej ? rs : "R10", "read count", 32'(rd_cnt), 32'(exp_rdc));
    chk(wr_cnt == exp_wrc, err ? "R11" : "R9", "write count", 32'(wr_cnt), 32'(exp_wrc));
    chk(!order_bad, "R7", "window before access", 32'(order_bad), 32'h0);
    if (!rej) begin
      chk(last_win == e_win(v.bus, v.dev), v.bus == 0 ? "R5" : "R6", "window value",
          last_win, e_win(v.bus, v.dev));
      if (rd_cnt > 0)
        chk(last_raddr == addr, v.bus == 0 ? "R5" : "R6", "read address", last_raddr, addr);
      if (wr_cnt > 0) begin
        chk(last_waddr == addr, v.bus == 0 ? "R5" : "R6", "write address", last_waddr, addr);
        chk(last_wdata == exp_wd, sub_wr ? "R9" : "R10", "write word", last_wdata, exp_wd);
      end
    end
    @(negedge clk);
    chk(req_ready == 1'b1 && done == 1'b0, "R1", "ready after done",
        {30'h0, req_ready, done}, 32'h2);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && !done && !win_we && !mem_valid, "R1", "reset state",
        {28'h0, req_ready, done, win_we, mem_valid}, 32'h8);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !done, "R1", "after reset", {30'h0, req_ready, done}, 32'h2);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R9 corner: offset 3 halfword write only touches the top byte
    run_vec('{1'b1, 1'b0, 8'd0, 5'd6, 3'd1, 8'h0B, 3'd2, 32'h0000_ABCD, 2'd0});
    // R8 corner: offset 3 halfword read returns a single byte
    run_vec('{1'b0, 1'b0, 8'd0, 5'd6, 3'd1, 8'h0B, 3'd2, 32'h0, 2'd0});
    // R4 corner: cardbus device 1 on a nonzero bus stays reachable
    run_vec('{1'b0, 1'b1, 8'd5, 5'd1, 3'd3, 8'h20, 3'd1, 32'h0, 2'd0});
    // R3 corner: device 15 on bus 0 is the last reachable slot
    run_vec('{1'b0, 1'b0, 8'd0, 5'd15, 3'd0, 8'h00, 3'd4, 32'h0, 2'd0});

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule